// File: doc/BRIEF.md
# ACPI power management event unit

This block holds the fixed power management register set of a platform controller: a free-running power management timer, a status register, an enable register and a control register. Software reaches them through a 16-bit write port and a 32-bit combinational read port, both selected by a 6-bit register offset. A second, byte-wide port carries an APM command byte and an APM status byte. From the stored state the block drives a level-sensitive system control interrupt (SCI). It also drives one-cycle request pulses toward the platform sequencer for power-off, system reset, S3 resume and SMI.

The timer advances once per `tick_i` strobe. In a real system that strobe runs at 3,579,545 Hz, so the whole block stays in one system clock domain. Each time the count crosses a half-range boundary (0x800000 with the default 24-bit width), the timer-overflow status bit is raised. A power-button input, gated by its enable bit, raises the power-button status bit.

Writing a sleep request (control bit 13 set) does not store bit 13. Depending on the sleep type, it asks the platform to power off or to reset and resume from S3.

Top module: `pm_event_unit`

## Requirements
- R1: While `rst_ni` is low, every register is cleared. Reads at offsets 0x00, 0x02, 0x04 and 0x08 return 0, `apm_cmd_o` and `apm_sts_o` are 0, and `sci_o`, `smi_o`, `poweroff_o`, `sys_reset_o` and `s3_resume_o` are low.
- R2: A write at offset 0x02 stores all 16 bits into the enable register. A write at offset 0x04 stores the value into the control register with bit 13 forced to 0. Reads at 0x00, 0x02 and 0x04 return status, enable and control, zero-extended to 32 bits.
- R3: The timer increments by one on each clock edge at which `tick_i` is high. It wraps at 2^TMR_W and reads at offset 0x08 zero-extended to 32 bits.
- R4: Status bit 0 is set on the edge at which the timer reaches a multiple of 2^(TMR_W-1). If that edge coincides with a status write that clears bit 0, the bit still ends up set.
- R5: `sci_o` is high exactly when (status AND enable AND 0x0521) is nonzero; mask bits 10, 8, 5 and 0. It follows a register change in the same cycle the register changes.
- R6: A write at offset 0x00 clears each status bit written as one and leaves the other status bits unchanged.
- R7: A cycle with `pwrbtn_i` high sets status bit 8 only if enable bit 8 is set. Otherwise the status register is unchanged.
- R8: A control write with bit 13 set takes the sleep type from bits 12:10. Type 0 pulses `poweroff_o`. Type 1 sets status bits 15 and 8 and pulses both `sys_reset_o` and `s3_resume_o`. Other types request nothing. Each pulse is high for exactly the one cycle after the write edge.
- R9: An APM write with `apm_sel_i` = 0 stores the byte, which then appears on `apm_cmd_o`. A byte of 0xF1 sets control bit 0 and 0xF0 clears it; other bytes leave the control register alone. When `smi_en_i` is high, every such write pulses `smi_o` for one cycle after the write edge.
- R10: An APM write with `apm_sel_i` = 1 stores the byte, which then appears on `apm_sts_o`. It has no effect on `apm_cmd_o`, on the control register or on `smi_o`.
- R11: Reads at offsets other than 0x00, 0x02, 0x04 and 0x08 return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer count strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register offset for reads and writes |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 32 | Read data for the addressed offset (combinational) |
| pwrbtn_i | input | 1 | Power-button event |
| apm_we_i | input | 1 | APM byte write strobe |
| apm_sel_i | input | 1 | APM byte select: 0 command, 1 status |
| apm_wdata_i | input | 8 | APM write byte |
| smi_en_i | input | 1 | Configuration: command writes raise SMI |
| apm_cmd_o | output | 8 | Stored APM command byte |
| apm_sts_o | output | 8 | Stored APM status byte |
| sci_o | output | 1 | System control interrupt level |
| smi_o | output | 1 | SMI request pulse |
| poweroff_o | output | 1 | Power-off request pulse |
| sys_reset_o | output | 1 | System reset request pulse |
| s3_resume_o | output | 1 | S3 resume request pulse |

## Verification
Every register updates on the clock edge that samples the write, tick or button strobe. Register reads and `sci_o` are combinational from those registers, so they are due right after that edge. The request pulses and `smi_o` come from registers loaded on the same edge: they are high for the one cycle after it and low again one cycle later. The bench drives every stimulus on a falling edge, lets exactly one rising edge act on it, samples on the next falling edge, and samples once more a cycle later to prove each pulse has ended. The timer tests count the exact number of rising edges with `tick_i` high, so the overflow boundary is checked both one tick before it and on it.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int OFF_W  = 6;
  localparam int DATA_W = 16;
  localparam int RD_W   = 32;
  localparam int APM_W  = 8;

  localparam logic [OFF_W-1:0] OFF_STS = 6'h00;
  localparam logic [OFF_W-1:0] OFF_EN  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TMR = 6'h08;

  localparam logic [DATA_W-1:0] SCI_MASK  = 16'h0521;
  localparam logic [DATA_W-1:0] STS_TMR_M = 16'h0001;
  localparam logic [DATA_W-1:0] STS_BTN_M = 16'h0100;
  localparam logic [DATA_W-1:0] STS_WAKE_M = 16'h8100;
  localparam logic [DATA_W-1:0] CTL_GO_M  = 16'h2000;

  localparam int EN_BTN_BIT = 8;
  localparam int CTL_GO_BIT = 13;
  localparam int SLP_LO     = 10;
  localparam int SLP_W      = 3;

  localparam logic [SLP_W-1:0] SLP_OFF = 3'd0;
  localparam logic [SLP_W-1:0] SLP_S3  = 3'd1;

  localparam logic [APM_W-1:0] APM_SCI_ON  = 8'hF1;
  localparam logic [APM_W-1:0] APM_SCI_OFF = 8'hF0;
endpackage

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [TMR_W-1:0] count_o,
  output logic             half_wrap_o
);
  logic [TMR_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else if (tick_i) count_q <= count_q + TMR_W'(1);
  end

  // next increment lands on a multiple of 2^(TMR_W-1)
  assign half_wrap_o = tick_i & (&count_q[TMR_W-2:0]);
  assign count_o     = count_q;
endmodule

// File: rtl/pm_apm.sv
module pm_apm
  import pm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [APM_W-1:0] wdata_i,
  input  logic             smi_en_i,
  output logic [APM_W-1:0] cmd_o,
  output logic [APM_W-1:0] sts_o,
  output logic             smi_o,
  output logic             sci_on_o,
  output logic             sci_off_o
);
  logic [APM_W-1:0] cmd_q, sts_q;
  logic             smi_q;
  logic             cmd_we;

  assign cmd_we = we_i & ~sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sts_q <= '0;
      smi_q <= 1'b0;
    end else begin
      smi_q <= cmd_we & smi_en_i;
      if (cmd_we) cmd_q <= wdata_i;
      if (we_i && sel_i) sts_q <= wdata_i;
    end
  end

  assign sci_on_o  = cmd_we & (wdata_i == APM_SCI_ON);
  assign sci_off_o = cmd_we & (wdata_i == APM_SCI_OFF);
  assign cmd_o     = cmd_q;
  assign sts_o     = sts_q;
  assign smi_o     = smi_q;
endmodule

// File: rtl/pm_regs.sv
module pm_regs
  import pm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sts_we_i,
  input  logic              en_we_i,
  input  logic              ctl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tmr_evt_i,
  input  logic              pwrbtn_i,
  input  logic              sci_on_i,
  input  logic              sci_off_i,
  output logic [DATA_W-1:0] sts_o,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] ctl_o,
  output logic              poweroff_o,
  output logic              sys_reset_o,
  output logic              s3_resume_o
);
  logic [DATA_W-1:0] sts_q, en_q, ctl_q;
  logic [DATA_W-1:0] sts_clr, sts_set;
  logic              off_q, rst_q, res_q;
  logic              slp_go, slp_off, slp_s3;
  logic [SLP_W-1:0]  slp_typ;

  assign slp_typ = wdata_i[SLP_LO +: SLP_W];
  assign slp_go  = ctl_we_i & wdata_i[CTL_GO_BIT];
  assign slp_off = slp_go & (slp_typ == SLP_OFF);
  assign slp_s3  = slp_go & (slp_typ == SLP_S3);

  always_comb begin
    sts_clr = sts_we_i ? wdata_i : '0;
    sts_set = '0;
    if (tmr_evt_i) sts_set = sts_set | STS_TMR_M;
    if (pwrbtn_i && en_q[EN_BTN_BIT]) sts_set = sts_set | STS_BTN_M;
    if (slp_s3) sts_set = sts_set | STS_WAKE_M;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
      off_q <= 1'b0;
      rst_q <= 1'b0;
      res_q <= 1'b0;
    end else begin
      // set sources win over a coincident clear
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (en_we_i) en_q <= wdata_i;
      if (ctl_we_i)       ctl_q    <= wdata_i & ~CTL_GO_M;
      else if (sci_on_i)  ctl_q[0] <= 1'b1;
      else if (sci_off_i) ctl_q[0] <= 1'b0;
      off_q <= slp_off;
      rst_q <= slp_s3;
      res_q <= slp_s3;
    end
  end

  assign sts_o       = sts_q;
  assign en_o        = en_q;
  assign ctl_o       = ctl_q;
  assign poweroff_o  = off_q;
  assign sys_reset_o = rst_q;
  assign s3_resume_o = res_q;
endmodule

// File: rtl/pm_event_unit.sv
module pm_event_unit
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [OFF_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0]   reg_rdata_o,
  input  logic              pwrbtn_i,
  input  logic              apm_we_i,
  input  logic              apm_sel_i,
  input  logic [APM_W-1:0]  apm_wdata_i,
  input  logic              smi_en_i,
  output logic [APM_W-1:0]  apm_cmd_o,
  output logic [APM_W-1:0]  apm_sts_o,
  output logic              sci_o,
  output logic              smi_o,
  output logic              poweroff_o,
  output logic              sys_reset_o,
  output logic              s3_resume_o
);
  logic [TMR_W-1:0]  tmr_cnt;
  logic              tmr_evt;
  logic [DATA_W-1:0] sts_q, en_q, ctl_q;
  logic              sci_on, sci_off;
  logic              sts_we, en_we, ctl_we;

  assign sts_we = reg_we_i & (reg_addr_i == OFF_STS);
  assign en_we  = reg_we_i & (reg_addr_i == OFF_EN);
  assign ctl_we = reg_we_i & (reg_addr_i == OFF_CTL);

  pm_timer #(.TMR_W(TMR_W)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .count_o     (tmr_cnt),
    .half_wrap_o (tmr_evt)
  );

  pm_apm i_apm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (apm_we_i),
    .sel_i     (apm_sel_i),
    .wdata_i   (apm_wdata_i),
    .smi_en_i  (smi_en_i),
    .cmd_o     (apm_cmd_o),
    .sts_o     (apm_sts_o),
    .smi_o     (smi_o),
    .sci_on_o  (sci_on),
    .sci_off_o (sci_off)
  );

  pm_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sts_we_i    (sts_we),
    .en_we_i     (en_we),
    .ctl_we_i    (ctl_we),
    .wdata_i     (reg_wdata_i),
    .tmr_evt_i   (tmr_evt),
    .pwrbtn_i    (pwrbtn_i),
    .sci_on_i    (sci_on),
    .sci_off_i   (sci_off),
    .sts_o       (sts_q),
    .en_o        (en_q),
    .ctl_o       (ctl_q),
    .poweroff_o  (poweroff_o),
    .sys_reset_o (sys_reset_o),
    .s3_resume_o (s3_resume_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_STS: reg_rdata_o[DATA_W-1:0] = sts_q;
      OFF_EN:  reg_rdata_o[DATA_W-1:0] = en_q;
      OFF_CTL: reg_rdata_o[DATA_W-1:0] = ctl_q;
      OFF_TMR: reg_rdata_o[TMR_W-1:0]  = tmr_cnt;
      default: reg_rdata_o = '0;
    endcase
  end

  assign sci_o = |(sts_q & en_q & SCI_MASK);
endmodule

// File: rtl/pm_event_unit_chk.sv
module pm_event_unit_chk
  import pm_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [TMR_W-1:0]  tmr_cnt,
  input logic [DATA_W-1:0] en_q,
  input logic              sci_o,
  input logic              smi_o,
  input logic              smi_en_i,
  input logic              apm_we_i,
  input logic              apm_sel_i,
  input logic              poweroff_o,
  input logic              sys_reset_o,
  input logic              s3_resume_o
);
  p_tmr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rst_ni) |=> tmr_cnt == $past(tmr_cnt) + TMR_W'(1));

  p_tmr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tmr_cnt));

  p_sci_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> (en_q & SCI_MASK) != '0);

  p_smi_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(apm_we_i && !apm_sel_i && smi_en_i));

  p_resume_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_o == s3_resume_o);

  p_off_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(poweroff_o && sys_reset_o));
endmodule

bind pm_event_unit pm_event_unit_chk #(.TMR_W(TMR_W)) i_chk (.*);

// File: tb/test_pm_event_unit.sv
module test_pm_event_unit;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwrbtn = 1'b0;
  logic        apm_we = 1'b0;
  logic        apm_sel = 1'b0;
  logic [7:0]  apm_wdata = '0;
  logic        smi_en = 1'b0;
  logic [7:0]  apm_cmd, apm_sts;
  logic        sci, smi, poff, sreset, s3res;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pm_event_unit #(.TMR_W(TW)) i_pm_event_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pwrbtn_i(pwrbtn), .apm_we_i(apm_we), .apm_sel_i(apm_sel),
    .apm_wdata_i(apm_wdata), .smi_en_i(smi_en),
    .apm_cmd_o(apm_cmd), .apm_sts_o(apm_sts), .sci_o(sci), .smi_o(smi),
    .poweroff_o(poff), .sys_reset_o(sreset), .s3_resume_o(s3res)
  );

  // {write offset, write data, read offset, expected read}
  localparam logic [43:0] VEC [7] = '{
    {6'h02, 16'hFFFF, 6'h02, 16'hFFFF},  // R2 enable full width
    {6'h02, 16'h0121, 6'h02, 16'h0121},  // R2
    {6'h04, 16'h0005, 6'h04, 16'h0005},  // R2 control
    {6'h04, 16'h0C05, 6'h04, 16'h0C05},  // R2 sleep type without go bit
    {6'h06, 16'hFFFF, 6'h06, 16'h0000},  // R11 undefined offset reads 0
    {6'h0A, 16'h1234, 6'h02, 16'h0121},  // R11 enable unchanged
    {6'h3E, 16'hFFFF, 6'h04, 16'h0C05}   // R11 control unchanged
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic apm_wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    apm_we = 1'b1; apm_sel = s; apm_wdata = d;
    @(negedge clk);
    apm_we = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(6'h00, v); check("R1 status", v, 0);
    rd(6'h02, v); check("R1 enable", v, 0);
    rd(6'h04, v); check("R1 control", v, 0);
    rd(6'h08, v); check("R1 timer", v, 0);
    check("R1 outputs", {apm_cmd, apm_sts, sci, smi, poff, sreset, s3res}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][43:38], VEC[i][37:22]);
      rd(VEC[i][21:16], v);
      check($sformatf("R2/R11 vector %0d", i), v, {16'h0, VEC[i][15:0]});
    end

    wr(6'h04, 16'h0000);
    wr(6'h02, 16'h0000);

    // R3, R4 timer and overflow status
    run_ticks(100);
    rd(6'h08, v); check("R3 timer count", v, 100);
    run_ticks(411);
    rd(6'h08, v); check("R3 timer before boundary", v, 511);
    rd(6'h00, v); check("R4 no overflow before boundary", v, 0);
    run_ticks(1);
    rd(6'h00, v); check("R4 overflow at boundary", v, 16'h0001);
    check("R5 sci off with enable 0", sci, 0);
    wr(6'h02, 16'h0020);
    check("R5 sci off, bit mismatch", sci, 0);
    wr(6'h02, 16'h0001);
    check("R5 sci on", sci, 1);
    run_ticks(510);
    run_ticks(1);
    rd(6'h08, v); check("R3 timer at top", v, 1023);
    // overflow edge coincides with a clear
    @(negedge clk);
    tick = 1'b1; we = 1'b1; addr = 6'h00; wdata = 16'h0001;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    rd(6'h08, v); check("R3 timer wrap", v, 0);
    rd(6'h00, v); check("R4 set wins over clear", v, 16'h0001);
    wr(6'h00, 16'h0001);
    rd(6'h00, v); check("R6 clear timer status", v, 0);
    check("R5 sci drops after clear", sci, 0);

    // R7 power button
    wr(6'h02, 16'h0000);
    @(negedge clk); pwrbtn = 1'b1; @(negedge clk); pwrbtn = 1'b0;
    rd(6'h00, v); check("R7 button ignored when disabled", v, 0);
    wr(6'h02, 16'h0100);
    @(negedge clk); pwrbtn = 1'b1; @(negedge clk); pwrbtn = 1'b0;
    rd(6'h00, v); check("R7 button sets status", v, 16'h0100);
    check("R5 sci from button", sci, 1);
    wr(6'h00, 16'hFFFF);
    rd(6'h00, v); check("R6 clear all", v, 0);

    // R8 sleep requests
    wr(6'h02, 16'h8000);
    @(negedge clk);
    we = 1'b1; addr = 6'h04; wdata = 16'h2000;
    @(negedge clk);
    we = 1'b0;
    check("R8 poweroff pulse", {poff, sreset, s3res}, 3'b100);
    rd(6'h04, v); check("R8 go bit not stored", v, 0);
    @(negedge clk);
    check("R8 poweroff one cycle", poff, 0);
    @(negedge clk);
    we = 1'b1; addr = 6'h04; wdata = 16'h2400;
    @(negedge clk);
    we = 1'b0;
    check("R8 reset and resume pulse", {poff, sreset, s3res}, 3'b011);
    rd(6'h00, v); check("R8 wake status", v, 16'h8100);
    rd(6'h04, v); check("R8 control type 1 stored", v, 16'h0400);
    check("R5 bit 15 not in mask", sci, 0);
    @(negedge clk);
    check("R8 reset pulse one cycle", {sreset, s3res}, 2'b00);
    wr(6'h02, 16'h0100);
    check("R5 sci from wake status", sci, 1);
    wr(6'h00, 16'h0100);
    rd(6'h00, v); check("R6 partial clear", v, 16'h8000);
    @(negedge clk);
    we = 1'b1; addr = 6'h04; wdata = 16'h2800;
    @(negedge clk);
    we = 1'b0;
    check("R8 type 2 no request", {poff, sreset, s3res}, 3'b000);
    rd(6'h04, v); check("R8 type 2 stored", v, 16'h0800);

    // R9, R10 APM bytes
    wr(6'h04, 16'h0000);
    smi_en = 1'b1;
    apm_wr(1'b0, 8'hF1);
    check("R9 smi pulse", smi, 1);
    check("R9 command readback", apm_cmd, 8'hF1);
    rd(6'h04, v); check("R9 0xF1 sets SCI enable", v, 16'h0001);
    @(negedge clk);
    check("R9 smi one cycle", smi, 0);
    smi_en = 1'b0;
    apm_wr(1'b0, 8'hF0);
    check("R9 no smi when disabled", smi, 0);
    rd(6'h04, v); check("R9 0xF0 clears SCI enable", v, 0);
    smi_en = 1'b1;
    apm_wr(1'b0, 8'h33);
    check("R9 smi on other command", smi, 1);
    rd(6'h04, v); check("R9 other command keeps control", v, 0);
    @(negedge clk);
    apm_wr(1'b1, 8'h5A);
    check("R10 status byte stored", apm_sts, 8'h5A);
    check("R10 command untouched", apm_cmd, 8'h33);
    check("R10 no smi", smi, 0);
    rd(6'h04, v); check("R10 control untouched", v, 0);

    finish_run();
  end
endmodule